// File: doc/BRIEF.md
# Centre Half-Sample Interpolator

This block produces the luma sample that sits halfway between four integer pixels in both directions. A row filter outside the block applies the six-tap kernel (1, -5, 20, 20, -5, 1) horizontally and passes on its raw sums without rounding or clipping. For each output position the block takes six of these sums, one from each of six consecutive rows. It applies the same kernel down the column, adds one rounding offset, shifts right by ten bits once, and clips the result to the 8-bit pixel range. The result is the same as running the vertical pass first and the horizontal pass second.

Each transfer carries eight independent lanes. Every lane holds six signed 16-bit intermediates and yields one 8-bit pixel. Transfers use a valid/ready handshake on both sides. Two register stages sit between input and output: the first keeps the symmetric tap pairs already folded, and the second keeps the clipped pixels. When the output is stalled, both stages hold.

Top module: `cip_centre_interp`

## Requirements
- R1: Within lane l, tap k (k = 0..5) sits at in_taps bits [(l*6+k)*16 +: 16] as a two's-complement value. The lane's pixel is clip((t0 - 5*t1 + 20*t2 + 20*t3 - 5*t4 + t5 + 512) >>> 10) to 0..255, where >>> is an arithmetic shift that rounds toward minus infinity.
- R2: A lane whose shifted result is negative outputs 0.
- R3: A lane whose shifted result is above 255 outputs 255.
- R4: A weighted sum of 512 gives 1, and a sum of 511 gives 0. A sum of -512 gives 0, and so does a sum of -513. Rounding is done only once.
- R5: No wrap-around occurs for any 16-bit tap values, including the full-scale extremes -32768 and 32767.
- R6: Lanes are independent. Lane l's pixel appears at out_pix bits [l*8 +: 8] and depends only on lane l's taps.
- R7: Results leave in the order they were accepted. A transfer accepted at one clock edge, followed by an edge at which in_ready is high, shows out_valid high after that second edge. out_valid is never high with nothing in flight.
- R8: While out_valid is high and out_ready is low, out_valid and out_pix keep their values at the next edge.
- R9: in_ready is low whenever out_valid is high and out_ready is low. At most two transfers are in flight.
- R10: After reset, out_valid is low and in_ready is high.
- R11: For any 6x6 patch of 8-bit pixels, two orders give the same pixel: feeding the unrounded horizontal row sums, or feeding the unrounded vertical column sums.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Block can take an input transfer |
| in_taps | input | 768 | Eight lanes of six signed 16-bit intermediates |
| out_valid | output | 1 | Output pixels present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_pix | output | 64 | Eight 8-bit centre pixels |

## Verification
The bench targets the rounding boundary at plus and minus 512. A design that rounds twice, or that truncates instead of adding the offset, misses these by one code. Weighted sums far below zero and far above 255 catch a missing clip or an unsigned compare, which would show up as wrapped low bytes. Full-scale taps at 32767 and -32768 catch an accumulator that is too narrow, because its sign flips and the clip lands at the wrong end. Random patches are fed both as row sums and as column sums, and random stalls on out_ready check that held data never changes and that no transfer is lost or duplicated.

// File: rtl/cip_pkg.sv
package cip_pkg;
    localparam int TAPS       = 6;
    localparam int RND_SHIFT  = 10;
    localparam int ACC_GUARD  = 7;
endpackage

// File: rtl/cip_fold.sv
module cip_fold #(
    parameter int IN_W = 16
) (
    input  logic [cip_pkg::TAPS*IN_W-1:0] taps,
    output logic signed [IN_W:0]          outer,
    output logic signed [IN_W:0]          mid,
    output logic signed [IN_W:0]          inner
);
    logic signed [IN_W-1:0] t [cip_pkg::TAPS];

    always_comb begin
        for (int k = 0; k < cip_pkg::TAPS; k++) begin
            t[k] = taps[k*IN_W +: IN_W];
        end
        outer = (IN_W+1)'(t[0]) + (IN_W+1)'(t[5]);
        mid   = (IN_W+1)'(t[1]) + (IN_W+1)'(t[4]);
        inner = (IN_W+1)'(t[2]) + (IN_W+1)'(t[3]);
    end
endmodule

// File: rtl/cip_round.sv
module cip_round #(
    parameter int IN_W  = 16,
    parameter int PIX_W = 8
) (
    input  logic signed [IN_W:0]  outer,
    input  logic signed [IN_W:0]  mid,
    input  logic signed [IN_W:0]  inner,
    output logic [PIX_W-1:0]      pix
);
    localparam int ACC_W = IN_W + cip_pkg::ACC_GUARD;
    localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1 << (cip_pkg::RND_SHIFT - 1));
    localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

    logic signed [ACC_W-1:0] o_x, m_x, i_x, acc, shifted;

    always_comb begin
        o_x = ACC_W'(outer);
        m_x = ACC_W'(mid);
        i_x = ACC_W'(inner);
        acc = o_x - ((m_x <<< 2) + m_x) + ((i_x <<< 4) + (i_x <<< 2)) + HALF;
        shifted = acc >>> cip_pkg::RND_SHIFT;
        if (shifted < 0) begin
            pix = '0;
        end else if (shifted > PIX_MAX) begin
            pix = '1;
        end else begin
            pix = shifted[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/cip_centre_interp.sv
module cip_centre_interp #(
    parameter int LANES = 8,
    parameter int IN_W  = 16,
    parameter int PIX_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_valid,
    output logic                                  in_ready,
    input  logic [LANES*cip_pkg::TAPS*IN_W-1:0]   in_taps,
    output logic                                  out_valid,
    input  logic                                  out_ready,
    output logic [LANES*PIX_W-1:0]                out_pix
);
    localparam int FW = IN_W + 1;
    localparam int TW = cip_pkg::TAPS * IN_W;

    typedef struct packed {
        logic signed [FW-1:0] outer;
        logic signed [FW-1:0] mid;
        logic signed [FW-1:0] inner;
    } fold_t;

    typedef struct packed {
        logic                     s1_v;
        fold_t [LANES-1:0]        s1;
        logic                     s2_v;
        logic [LANES*PIX_W-1:0]   s2;
    } pipe_t;

    pipe_t st_d, st_q;

    logic signed [FW-1:0]   f_out [LANES];
    logic signed [FW-1:0]   f_mid [LANES];
    logic signed [FW-1:0]   f_inn [LANES];
    logic [LANES*PIX_W-1:0] pix_w;
    logic                   advance;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        cip_fold #(.IN_W(IN_W)) u_fold (
            .taps  (in_taps[l*TW +: TW]),
            .outer (f_out[l]),
            .mid   (f_mid[l]),
            .inner (f_inn[l])
        );
        cip_round #(.IN_W(IN_W), .PIX_W(PIX_W)) u_round (
            .outer (st_q.s1[l].outer),
            .mid   (st_q.s1[l].mid),
            .inner (st_q.s1[l].inner),
            .pix   (pix_w[l*PIX_W +: PIX_W])
        );
    end

    assign advance   = !st_q.s2_v || out_ready;
    assign in_ready  = advance;
    assign out_valid = st_q.s2_v;
    assign out_pix   = st_q.s2;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.s2_v = st_q.s1_v;
            st_d.s2   = pix_w;
            st_d.s1_v = in_valid;
            for (int l = 0; l < LANES; l++) begin
                st_d.s1[l].outer = f_out[l];
                st_d.s1[l].mid   = f_mid[l];
                st_d.s1[l].inner = f_inn[l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cip_centre_chk.sv
module cip_centre_chk #(
    parameter int LANES = 8,
    parameter int PIX_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [LANES*PIX_W-1:0] out_pix
);
    logic [2:0] inflight;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + 3'((in_valid && in_ready) ? 1 : 0)
                                 - 3'((out_valid && out_ready) ? 1 : 0);
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix))); // R8

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) ##1 in_ready |=> out_valid); // R7

    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight != 3'd0)); // R7

    AST_BOUNDED_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        inflight <= 3'd2); // R9

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && in_ready)); // R10
endmodule

bind cip_centre_interp cip_centre_chk #(.LANES(LANES), .PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix)
);

// File: tb/cip_centre_interp_test.sv
module cip_centre_interp_test;
    localparam int LANES = 8;
    localparam int IN_W  = 16;
    localparam int TAPW  = LANES * 6 * IN_W;
    localparam int PIXW  = LANES * 8;

    logic            clk = 0;
    logic            rst = 1;
    logic            in_valid = 0;
    logic            in_ready;
    logic [TAPW-1:0] in_taps = '0;
    logic            out_valid;
    logic            out_ready = 1;
    logic [PIXW-1:0] out_pix;

    int vectors = 0;
    int errors  = 0;
    bit rand_stall = 0;
    bit done = 0;
    logic [PIXW-1:0] sb [$];

    cip_centre_interp uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_taps(in_taps), .out_valid(out_valid), .out_ready(out_ready),
        .out_pix(out_pix)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] ref_px(int a, int b, int c, int d, int e, int f);
        int s;
        s = a - 5*b + 20*c + 20*d - 5*e + f;
        s = (s + 512) >>> 10;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return 8'(s);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [TAPW-1:0] taps, input logic [PIXW-1:0] exp);
        @(negedge clk);
        in_taps  = taps;
        in_valid = 1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        sb.push_back(exp);
        #1;
        in_valid = 0;
    endtask

    // Stall generator
    always @(negedge clk) begin
        if (rand_stall) out_ready <= ($urandom % 4) != 0;
        else            out_ready <= 1'b1;
    end

    // Monitor / scoreboard
    logic            prev_stall = 0;
    logic [PIXW-1:0] prev_pix   = '0;
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (prev_stall) begin
                check("R8 hold valid", 64'(out_valid), 64'd1);
                check("R8 hold pix", 64'(out_pix), 64'(prev_pix));
            end
            if (out_valid && !out_ready)
                check("R9 ready low in stall", 64'(in_ready), 64'd0);
            if (out_valid && out_ready) begin
                if (sb.size() == 0) begin
                    check("R7 unexpected output", 64'd1, 64'd0);
                end else begin
                    logic [PIXW-1:0] e;
                    e = sb.pop_front();
                    for (int l = 0; l < LANES; l++)
                        check($sformatf("R1/R6 lane %0d", l),
                              64'(out_pix[l*8 +: 8]), 64'(e[l*8 +: 8]));
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_pix   = out_pix;
        end
    end

    task automatic put_lane(inout logic [TAPW-1:0] tw, input int l,
                            input int a, input int b, input int c,
                            input int d, input int e, input int f);
        tw[(l*6+0)*IN_W +: IN_W] = 16'(a);
        tw[(l*6+1)*IN_W +: IN_W] = 16'(b);
        tw[(l*6+2)*IN_W +: IN_W] = 16'(c);
        tw[(l*6+3)*IN_W +: IN_W] = 16'(d);
        tw[(l*6+4)*IN_W +: IN_W] = 16'(e);
        tw[(l*6+5)*IN_W +: IN_W] = 16'(f);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [TAPW-1:0] tw;
        logic [PIXW-1:0] ex;
        int wgt [6] = '{1, -5, 20, 20, -5, 1};
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #2;
        check("R10 out_valid after reset", 64'(out_valid), 64'd0);
        check("R10 in_ready after reset", 64'(in_ready), 64'd1);

        // R4 rounding edges, R2, R3, R5 in distinct lanes (R6)
        tw = '0;
        put_lane(tw, 0, 512, 0, 0, 0, 0, 0);          ex[7:0]   = 8'd1;   // R4
        put_lane(tw, 1, 511, 0, 0, 0, 0, 0);          ex[15:8]  = 8'd0;   // R4
        put_lane(tw, 2, -512, 0, 0, 0, 0, 0);         ex[23:16] = 8'd0;   // R4
        put_lane(tw, 3, -513, 0, 0, 0, 0, 0);         ex[31:24] = 8'd0;   // R4, R2
        put_lane(tw, 4, 0, 1000, 0, 0, 0, 0);         ex[39:32] = 8'd0;   // R2
        put_lane(tw, 5, 0, 0, 20000, 0, 0, 0);        ex[47:40] = 8'd255; // R3
        put_lane(tw, 6, 32767, -32768, 32767, 32767, -32768, 32767);
        ex[55:48] = 8'd255;                                               // R5
        put_lane(tw, 7, -32768, 32767, -32768, -32768, 32767, -32768);
        ex[63:56] = 8'd0;                                                 // R5
        send(tw, ex);
        tw = '0;
        put_lane(tw, 0, 1535, 0, 0, 0, 0, 0);         ex[7:0]   = 8'd1;   // R4
        put_lane(tw, 1, 1536, 0, 0, 0, 0, 0);         ex[15:8]  = 8'd2;   // R4
        put_lane(tw, 2, 0, 0, 0, 12800, 0, 0);        ex[23:16] = 8'd250; // R1
        for (int l = 3; l < LANES; l++) begin
            put_lane(tw, l, 0, 0, 1024*l, 0, 0, 0);
            ex[l*8 +: 8] = ref_px(0, 0, 1024*l, 0, 0, 0);
        end
        send(tw, ex);

        // R7 latency with an idle pipe
        repeat (4) @(posedge clk);
        tw = '0;
        put_lane(tw, 0, 0, 0, 2048, 2048, 0, 0);
        ex = '0; ex[7:0] = 8'd80;
        @(negedge clk);
        in_taps = tw; in_valid = 1;
        @(posedge clk);
        sb.push_back(ex);
        #2;
        check("R7 not yet valid", 64'(out_valid), 64'd0);
        @(negedge clk);
        in_valid = 0;
        @(posedge clk);
        #2;
        check("R7 valid after two edges", 64'(out_valid), 64'd1);

        // R1 random taps with random stalls (R8, R9)
        rand_stall = 1;
        for (int n = 0; n < 200; n++) begin
            for (int l = 0; l < LANES; l++) begin
                int v [6];
                for (int k = 0; k < 6; k++) v[k] = int'($urandom_range(15000)) - 3000;
                put_lane(tw, l, v[0], v[1], v[2], v[3], v[4], v[5]);
                ex[l*8 +: 8] = ref_px(v[0], v[1], v[2], v[3], v[4], v[5]);
            end
            send(tw, ex);
        end

        // R11 row-first against column-first on random patches
        for (int n = 0; n < 150; n++) begin
            logic [TAPW-1:0] tv;
            logic [PIXW-1:0] ev;
            for (int l = 0; l < LANES; l++) begin
                int px [6][6];
                int hs [6];
                int vs [6];
                for (int r = 0; r < 6; r++)
                    for (int c = 0; c < 6; c++) px[r][c] = int'($urandom_range(255));
                if (n < 4) for (int r = 0; r < 6; r++)
                    for (int c = 0; c < 6; c++) px[r][c] = ((r == 1 || r == 4) ^ (c == 1 || c == 4)) ? 255 : 0;
                for (int i = 0; i < 6; i++) begin
                    hs[i] = 0; vs[i] = 0;
                    for (int j = 0; j < 6; j++) begin
                        hs[i] += wgt[j] * px[i][j];
                        vs[i] += wgt[j] * px[j][i];
                    end
                end
                ex[l*8 +: 8] = ref_px(vs[0], vs[1], vs[2], vs[3], vs[4], vs[5]);
                ev[l*8 +: 8] = ref_px(hs[0], hs[1], hs[2], hs[3], hs[4], hs[5]);
                check("R11 orders agree", 64'(ex[l*8 +: 8]), 64'(ev[l*8 +: 8]));
                put_lane(tw, l, hs[0], hs[1], hs[2], hs[3], hs[4], hs[5]);
                put_lane(tv, l, vs[0], vs[1], vs[2], vs[3], vs[4], vs[5]);
            end
            send(tw, ex);  // R11 row sums, expected from column-first
            send(tv, ev);  // R11 column sums, expected from row-first
        end

        rand_stall = 0;
        for (int w = 0; w < 100 && sb.size() != 0; w++) @(posedge clk);
        repeat (3) @(posedge clk);
        check("R7 all results drained", 64'(sb.size()), 64'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule